// File: doc/BRIEF.md
# Paged Read Sequencer with CRC16 Insertion

This block is the memory-layer engine that serves read commands for a 2048-byte data array and a sparse status array. A byte-level bus interface hands it one command byte and two address bytes on a valid/ready input stream. The engine then reads bytes from a synchronous memory port and sends them out on a valid/ready output stream. At points set by the command, it inserts the complement of a running CRC16 into the stream. Three read commands are served. The first is a flat read through the end of memory. The second is a status read with a CRC after every 8-byte status page. The third is an extended read that runs page by page. For each 32-byte page it first reports the page's redirection byte and a CRC, then streams the page data and a second CRC. The engine only passes the redirection byte on and takes no action on its value.

Bit timing, bus reset detection and programming are handled by neighbouring logic. A session reset from that logic (`sess_clr`) aborts any transfer and returns the engine to waiting for a command. Back-pressure rules are as follows. An output byte, once `tx_valid` is high, stays unchanged until it is taken with `tx_ready`. Input bytes are taken only while the engine waits for a command or for address bytes. `rx_ready` is never high while output is pending.

Top module: `pgread_seq`

## Requirements
- R1: After `rst_n` is released, `tx_valid` is 0, `rx_ready` is 1 and `mem_rd_en` is 0.
- R2: The engine recognises three command bytes: F0h (flat read), AAh (status read) and A5h (extended read). Any other command byte leaves `rx_ready` and `tx_valid` at 0 until `sess_clr`.
- R3: After the command, the next input byte is the address low byte and the one after it is the high byte. Only the 3 low bits of the high byte are kept, giving an 11-bit start address. The CRC takes in this masked high byte.
- R4: A flat read sends the data bytes from the start address up to 7FFh. It then sends a CRC over the command byte, the two address bytes and every data byte sent.
- R5: A status read sends a CRC after each byte whose address ends in binary 111. The first CRC covers the command, the address and the data. Each later CRC covers only that page's data, starting from zero.
- R6: Status addresses 000h-007h, 020h-027h, 040h-047h and 100h-13Fh are backed by memory. All other status addresses return FFh without a memory read.
- R7: An extended read first sends the redirection byte of the addressed page (status address 100h + page, where page is address bits 10:5). It then sends a CRC over the command, the address and that byte. Next it sends data up to the end of the 32-byte page, then a CRC over that data only.
- R8: For each later page, an extended read sends the page's redirection byte, a CRC over that byte alone, the 32 data bytes and a CRC over them.
- R9: The CRC is reflected CRC16 with polynomial x^16+x^15+x^2+1 (A001h), initial value 0. Each byte is taken LSB first. It is sent complemented, low byte first.
- R10: After the final CRC of a command, every further output byte is FFh until `sess_clr`.
- R11: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` holds its value. `rx_ready` is 0 whenever `tx_valid` is 1.
- R12: `sess_clr` aborts the transfer at any point without sending a CRC. In the next cycle `tx_valid` is 0 and `rx_ready` is 1, and a new command is then served normally.
- R13: The memory port has one cycle of latency. `mem_rd_data` is used in the cycle after `mem_rd_en`, and `mem_sel` is 1 for status and 0 for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_clr | input | 1 | Session reset from the bus layer; aborts any command |
| rx_valid | input | 1 | Input byte valid |
| rx_ready | output | 1 | Engine accepts an input byte |
| rx_data | input | 8 | Command or address byte |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Bus layer takes the output byte |
| tx_data | output | 8 | Data, redirection, CRC or fill byte |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_sel | output | 1 | 1 = status array, 0 = data array |
| mem_addr | output | 11 | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |

## Verification
The hardest situation to reach is the extended read crossing a page boundary. The CRC must clear twice there: once after the data CRC and again after the redirection CRC. In addition, the next redirection byte must come from status address 100h plus the new page. To reach it, the bench starts an extended read three bytes before the end of page 1 and reads on through all of page 2. It checks each CRC against one computed from the requirement. A second extended read starts two bytes before 7FFh, so the last-page CRC is followed by FFh fill. A status read that begins inside an implemented range and runs into the unimplemented hole shows the cleared second CRC and the FFh gap bytes.

// File: rtl/pgread_pkg.sv
package pgread_pkg;
  localparam logic [7:0] CMD_FLAT = 8'hF0;
  localparam logic [7:0] CMD_STAT = 8'hAA;
  localparam logic [7:0] CMD_EXT  = 8'hA5;

  typedef enum logic [1:0] {MODE_FLAT, MODE_STAT, MODE_EXT} mode_t;

  typedef enum logic [3:0] {
    S_IDLE, S_ALO, S_AHI, S_FETCH, S_LOAD, S_DATA, S_CLO, S_CHI, S_FILL, S_DEAD
  } seq_state_t;

  localparam int unsigned STAT_NRANGE = 4;
  localparam int unsigned STAT_LO [STAT_NRANGE] = '{32'h000, 32'h020, 32'h040, 32'h100};
  localparam int unsigned STAT_HI [STAT_NRANGE] = '{32'h007, 32'h027, 32'h047, 32'h13F};
endpackage

// File: rtl/pgread_crc16.sv
module pgread_crc16 #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'hA001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [7:0]   din,
  output logic [W-1:0] crc
);
  function automatic logic [W-1:0] step(input logic [W-1:0] c, input logic [7:0] d);
    logic [W-1:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (en)  crc <= step(clr ? '0 : crc, din);
    else if (clr) crc <= '0;
  end

  // R9: a pure clear leaves a zero seed
  a_r9_clear_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !en) |=> (crc == '0));
endmodule

// File: rtl/pgread_stat_map.sv
module pgread_stat_map
  import pgread_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [STAT_NRANGE-1:0] in_rng;
  logic [31:0]            addr32;

  assign addr32 = {{(32-AW){1'b0}}, addr};

  for (genvar g = 0; g < STAT_NRANGE; g++) begin : g_rng
    assign in_rng[g] = (addr32 >= STAT_LO[g]) && (addr32 <= STAT_HI[g]);
  end

  assign hit = |in_rng;
endmodule

// File: rtl/pgread_fetch.sv
module pgread_fetch #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_stat,
  input  logic [AW-1:0] req_addr,
  output logic          mem_rd_en,
  output logic          mem_sel,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rd_data,
  output logic [7:0]    byte_out
);
  logic map_hit;
  logic live_q;

  pgread_stat_map #(.AW(AW)) u_map (.addr(req_addr), .hit(map_hit));

  assign mem_rd_en = req && (!req_stat || map_hit);
  assign mem_sel   = req_stat;
  assign mem_addr  = req_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   live_q <= 1'b0;
    else if (req) live_q <= mem_rd_en;
  end

  // R13: one-cycle latency; R6: holes read as all ones
  assign byte_out = live_q ? mem_rd_data : 8'hFF;

  // R6: status reads never land above the last implemented location
  a_r6_no_hole_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_sel) |-> ({{(32-AW){1'b0}}, mem_addr} <= 32'h13F));
endmodule

// File: rtl/pgread_seq.sv
module pgread_seq
  import pgread_pkg::*;
#(
  parameter int          ADDR_W     = 11,
  parameter int          DPAGE_W    = 5,
  parameter int          SPAGE_W    = 3,
  parameter int          CRC_W      = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'hA001,
  parameter logic [ADDR_W-1:0] REDIR_BASE = 11'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_clr,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              mem_rd_en,
  output logic              mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rd_data
);
  localparam int         HI_W    = ADDR_W - 8;
  localparam logic [7:0] HI_MASK = 8'((1 << HI_W) - 1);
  localparam int         PAGE_W  = ADDR_W - DPAGE_W;

  seq_state_t        state;
  mode_t             mode;
  logic [ADDR_W-1:0] addr;
  logic              in_red;
  logic              tx_valid_q;
  logic [7:0]        tx_data_q;

  logic              rx_hs, tx_hs;
  logic              crc_clr, crc_en;
  logic [7:0]        crc_din;
  logic [CRC_W-1:0]  crc;
  logic              f_req, f_stat;
  logic [ADDR_W-1:0] f_addr;
  logic [7:0]        f_byte;
  logic              seg_end, at_top;
  logic [PAGE_W-1:0] page;

  assign rx_ready = (state == S_IDLE) || (state == S_ALO) || (state == S_AHI);
  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;
  assign rx_hs    = rx_valid && rx_ready;
  assign tx_hs    = tx_valid_q && tx_ready;

  assign page   = addr[ADDR_W-1:DPAGE_W];
  assign at_top = &addr;

  always_comb begin
    unique case (mode)
      MODE_FLAT: seg_end = at_top;
      MODE_STAT: seg_end = &addr[SPAGE_W-1:0];
      default:   seg_end = &addr[DPAGE_W-1:0];
    endcase
  end

  // CRC control: seeded by the command, cleared between segments
  always_comb begin
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    crc_din = rx_data;
    if (sess_clr) begin
      crc_clr = 1'b1;
    end else begin
      unique case (state)
        S_IDLE:  begin crc_clr = rx_hs; crc_en = rx_hs; end
        S_ALO:   crc_en = rx_hs;
        S_AHI:   begin crc_en = rx_hs; crc_din = rx_data & HI_MASK; end
        S_LOAD:  begin crc_en = 1'b1; crc_din = f_byte; end
        S_CHI:   crc_clr = tx_hs;
        default: ;
      endcase
    end
  end

  pgread_crc16 #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(crc_din), .crc(crc)
  );

  assign f_req  = (state == S_FETCH) && !sess_clr;
  assign f_stat = (mode == MODE_STAT) || in_red;
  assign f_addr = in_red ? (REDIR_BASE + ADDR_W'(page)) : addr;

  pgread_fetch #(.AW(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .req(f_req), .req_stat(f_stat), .req_addr(f_addr),
    .mem_rd_en(mem_rd_en), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data), .byte_out(f_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      mode       <= MODE_FLAT;
      addr       <= '0;
      in_red     <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_data_q  <= 8'hFF;
    end else if (sess_clr) begin
      state      <= S_IDLE;
      in_red     <= 1'b0;
      tx_valid_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (rx_hs) begin
          in_red <= 1'b0;
          unique case (rx_data)
            CMD_FLAT: begin mode <= MODE_FLAT; state <= S_ALO; end
            CMD_STAT: begin mode <= MODE_STAT; state <= S_ALO; end
            CMD_EXT:  begin mode <= MODE_EXT;  state <= S_ALO; in_red <= 1'b1; end
            default:  state <= S_DEAD;
          endcase
        end
        S_ALO: if (rx_hs) begin
          addr[7:0] <= rx_data;
          state     <= S_AHI;
        end
        S_AHI: if (rx_hs) begin
          addr[ADDR_W-1:8] <= rx_data[HI_W-1:0];
          state            <= S_FETCH;
        end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          tx_data_q  <= f_byte;
          tx_valid_q <= 1'b1;
          state      <= S_DATA;
        end
        S_DATA: if (tx_hs) begin
          if (in_red || seg_end) begin
            tx_data_q <= ~crc[7:0];
            state     <= S_CLO;
          end else begin
            tx_valid_q <= 1'b0;
            addr       <= addr + 1'b1;
            state      <= S_FETCH;
          end
        end
        S_CLO: if (tx_hs) begin
          tx_data_q <= ~crc[CRC_W-1:8];
          state     <= S_CHI;
        end
        S_CHI: if (tx_hs) begin
          if (in_red) begin
            in_red     <= 1'b0;
            tx_valid_q <= 1'b0;
            state      <= S_FETCH;
          end else if (mode == MODE_FLAT || at_top) begin
            tx_data_q <= 8'hFF;
            state     <= S_FILL;
          end else begin
            addr       <= addr + 1'b1;
            in_red     <= (mode == MODE_EXT);
            tx_valid_q <= 1'b0;
            state      <= S_FETCH;
          end
        end
        S_FILL:  tx_valid_q <= 1'b1;
        default: ;
      endcase
    end
  end

  // R11: a pending output byte is held until taken
  a_r11_hold_byte: assert property (@(posedge clk) disable iff (!rst_n || sess_clr)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R11: input and output never both open
  a_r11_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> !tx_valid);

  // R10: fill bytes are all ones
  a_r10_fill_ones: assert property (@(posedge clk) disable iff (!rst_n || sess_clr)
    (state == S_FILL) |=> (tx_valid && tx_data == 8'hFF));

  // R12: session clear reopens the input side
  a_r12_abort: assert property (@(posedge clk) disable iff (!rst_n)
    sess_clr |=> (!tx_valid && rx_ready));

  // R2: an unknown command silences both streams
  a_r2_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n || sess_clr)
    (state == S_DEAD) |=> (!tx_valid && !rx_ready && !mem_rd_en));
endmodule

// File: tb/sim_pgread_seq.sv
module sim_pgread_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sess_clr = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic        mem_rd_en;
  logic        mem_sel;
  logic [10:0] mem_addr;
  logic [7:0]  mem_rd_data = 8'h00;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pgread_seq u0 (
    .clk(clk), .rst_n(rst_n), .sess_clr(sess_clr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .mem_rd_en(mem_rd_en), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_rd_data(mem_rd_data)
  );

  function automatic logic [7:0] dpat(input logic [10:0] a);
    return (a[7:0] * 8'd3) ^ {5'b0, a[10:8]} ^ 8'h6C;
  endfunction

  function automatic bit simpl(input logic [10:0] a);
    return (a <= 11'h007) || (a >= 11'h020 && a <= 11'h027) ||
           (a >= 11'h040 && a <= 11'h047) || (a >= 11'h100 && a <= 11'h13F);
  endfunction

  // raw array content; holes hold 00h so a stray read would show
  function automatic logic [7:0] sraw(input logic [10:0] a);
    return simpl(a) ? (a[7:0] ^ 8'hC3 ^ (a[8] ? 8'h11 : 8'h00)) : 8'h00;
  endfunction

  function automatic logic [7:0] sexp(input logic [10:0] a);
    return simpl(a) ? sraw(a) : 8'hFF;
  endfunction

  function automatic logic [15:0] crcb(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      r = ((r[0] ^ b[i]) != 1'b0) ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    end
    return r;
  endfunction

  // R13: synchronous memory, one cycle of latency
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem_sel ? sraw(mem_addr) : dpat(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    tx_ready = 1'b1;
    @(posedge clk);
    #1 tx_ready = 1'b0;
  endtask

  task automatic expect_byte(input logic [7:0] exp, input string req);
    logic [7:0] b;
    get(b);
    chk(b == exp, req, b, exp);
  endtask

  task automatic expect_crc(input logic [15:0] c, input string req);
    expect_byte(~c[7:0], req);
    expect_byte(~c[15:8], req);
  endtask

  task automatic clear_session;
    @(negedge clk);
    sess_clr = 1'b1;
    @(negedge clk);
    sess_clr = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!tx_valid && rx_ready && !mem_rd_en, "R1 reset state", {tx_valid, rx_ready, mem_rd_en}, 3'b010);
  endtask

  // R3 R4 R9 R10: flat read from 7F0h with junk in the high address bits
  task automatic t_flat_tail;
    logic [15:0] c;
    put(8'hF0); put(8'hF0); put(8'hFF);
    c = crcb(crcb(crcb(16'h0, 8'hF0), 8'hF0), 8'h07);
    for (int a = 11'h7F0; a <= 11'h7FF; a++) begin
      expect_byte(dpat(11'(a)), "R4 R3 flat data");
      c = crcb(c, dpat(11'(a)));
    end
    expect_crc(c, "R4 R9 flat crc");
    for (int k = 0; k < 3; k++) expect_byte(8'hFF, "R10 flat fill");
    clear_session;
  endtask

  // R12: abort mid-stream, then a new command works
  task automatic t_abort;
    put(8'hF0); put(8'h10); put(8'h00);
    for (int a = 16; a < 21; a++) expect_byte(dpat(11'(a)), "R4 flat data");
    clear_session;
    chk(!tx_valid && rx_ready, "R12 abort state", {tx_valid, rx_ready}, 2'b01);
    put(8'hAA); put(8'h20); put(8'h00);
    expect_byte(sexp(11'h020), "R12 restart status");
    clear_session;
  endtask

  // R5 R6: status pages across an implemented block into a hole
  task automatic t_status;
    logic [15:0] c;
    put(8'hAA); put(8'h04); put(8'h00);
    c = crcb(crcb(crcb(16'h0, 8'hAA), 8'h04), 8'h00);
    for (int a = 4; a < 8; a++) begin
      expect_byte(sexp(11'(a)), "R5 status data");
      c = crcb(c, sexp(11'(a)));
    end
    expect_crc(c, "R5 first status crc");
    c = 16'h0;
    for (int a = 8; a < 16; a++) begin
      expect_byte(8'hFF, "R6 status hole");
      c = crcb(c, 8'hFF);
    end
    expect_crc(c, "R5 later status crc");
    clear_session;
  endtask

  // R6 R10: last status page ends the command
  task automatic t_status_top;
    logic [15:0] c;
    put(8'hAA); put(8'hFC); put(8'h07);
    c = crcb(crcb(crcb(16'h0, 8'hAA), 8'hFC), 8'h07);
    for (int a = 11'h7FC; a <= 11'h7FF; a++) begin
      expect_byte(8'hFF, "R6 top status");
      c = crcb(c, 8'hFF);
    end
    expect_crc(c, "R5 top status crc");
    expect_byte(8'hFF, "R10 status fill");
    clear_session;
  endtask

  // R7 R8: extended read across the page 1 / page 2 boundary
  task automatic t_ext_cross;
    logic [15:0] c;
    logic [7:0]  r;
    put(8'hA5); put(8'h3D); put(8'h00);
    r = sexp(11'h101);
    expect_byte(r, "R7 first redirection byte");
    c = crcb(crcb(crcb(crcb(16'h0, 8'hA5), 8'h3D), 8'h00), r);
    expect_crc(c, "R7 redirection crc");
    c = 16'h0;
    for (int a = 11'h03D; a <= 11'h03F; a++) begin
      expect_byte(dpat(11'(a)), "R7 page data");
      c = crcb(c, dpat(11'(a)));
    end
    expect_crc(c, "R7 page crc");
    r = sexp(11'h102);
    expect_byte(r, "R8 next redirection byte");
    expect_crc(crcb(16'h0, r), "R8 redirection-only crc");
    c = 16'h0;
    for (int a = 11'h040; a <= 11'h05F; a++) begin
      expect_byte(dpat(11'(a)), "R8 next page data");
      c = crcb(c, dpat(11'(a)));
    end
    expect_crc(c, "R8 next page crc");
    clear_session;
  endtask

  // R7 R10: extended read on the last page
  task automatic t_ext_last;
    logic [15:0] c;
    logic [7:0]  r;
    put(8'hA5); put(8'hFE); put(8'h07);
    r = sexp(11'h13F);
    expect_byte(r, "R7 last redirection byte");
    c = crcb(crcb(crcb(crcb(16'h0, 8'hA5), 8'hFE), 8'h07), r);
    expect_crc(c, "R7 last redirection crc");
    c = crcb(crcb(16'h0, dpat(11'h7FE)), dpat(11'h7FF));
    expect_byte(dpat(11'h7FE), "R7 last data");
    expect_byte(dpat(11'h7FF), "R7 last data");
    expect_crc(c, "R7 last page crc");
    for (int k = 0; k < 3; k++) expect_byte(8'hFF, "R10 ext fill");
    clear_session;
  endtask

  // R2: unknown command
  task automatic t_badcmd;
    bit quiet;
    put(8'h33);
    quiet = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (tx_valid || rx_ready) quiet = 1'b0;
    end
    chk(quiet, "R2 unknown command silent", quiet, 1);
    clear_session;
    chk(rx_ready, "R2 recovers after clear", rx_ready, 1);
  endtask

  // R11: back-pressure holds the byte, input stays closed
  task automatic t_backpressure;
    logic [7:0] first;
    bit held;
    put(8'hF0); put(8'h00); put(8'h00);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    first = tx_data;
    held = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (!tx_valid || tx_data != first || rx_ready) held = 1'b0;
    end
    chk(held, "R11 hold under back-pressure", held, 1);
    expect_byte(dpat(11'h000), "R11 held byte value");
    expect_byte(dpat(11'h001), "R11 next byte");
    clear_session;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_flat_tail;
    t_abort;
    t_status;
    t_status_top;
    t_ext_cross;
    t_ext_last;
    t_badcmd;
    t_backpressure;
    done = 1'b1;
    summary;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary;
    end
  end
endmodule